// File: doc/BRIEF.md
# Wired-to-Message Interrupt Converter

This block sits between a bank of level or pulse interrupt wires and a message-based interrupt fabric. Each wire is brought into the local clock domain through a two-flop synchronizer. A per-pin trigger mode selects rising-edge or level-high detection. When a pin fires, the block sets that pin's pending bit. It then issues exactly one write request carrying the pin's configured device and event identifiers to a doorbell address that is fixed in hardware.

Software configures the block through a simple 32-bit read/write register port. It programs a trigger-mode bank and one vector word per pin. It acknowledges a serviced interrupt by writing ones into a write-1-to-clear bank, and reading that bank returns the current pending bits. While its pending bit is set, a pin stays silent. When several pins are owed a message, a round-robin arbiter chooses which one is sent next. The message leaves on a valid/ready interface.

Top module: `wire2msg_bridge`

## Requirements
- R1: After reset, `msg_valid` is 0 and every trigger-mode word, vector word and pending word reads back 0, so every pin is rising-edge with zero identifiers.
- R2: The vector word of pin p sits at byte offset 0x200 + 4*p. Bits [11:0] hold the device ID, bits [21:12] hold the event ID, and bits [31:22] read 0. A read-modify-write that changes only the event field leaves the device field unchanged.
- R3: The trigger-mode bit of pin p is bit p%32 of the word at offset 4*(p/32). A value of 1 selects level-high triggering and 0 selects rising-edge triggering.
- R4: The pending bit of pin p is bit p%32 of the word at offset 0xA000 + 4*(p/32). Writing 1 clears that bit, writing 0 leaves it unchanged, and a read returns the pending bits.
- R5: A firing pin sets its pending bit and produces one message with `msg_dev` = device ID, `msg_evt` = event ID and `msg_addr` = the DOORBELL parameter. A rising-edge pin fires on a 0-to-1 transition of its synchronized input.
- R6: While a pin's pending bit is set, the pin produces no message. A level-high pin whose input is still 1 fires again once its pending bit is cleared.
- R7: Each accepted handshake (`msg_valid` and `msg_ready` both 1 at a clock edge) consumes one message. `msg_valid` is 0 in the following cycle.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_dev` and `msg_evt` hold their values.
- R9: Owed messages are sent in round-robin order. The next pin is the first owed pin in ascending cyclic order after the pin sent last. After reset, pin 0 comes first.
- R10: Reads of any offset outside the three banks return 0, and writes there change no register.
- R11: `cfg_rdata` is updated at the clock edge where `cfg_rd_en` is 1, and its value is valid in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Asynchronous wired interrupt inputs |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 16 | Byte offset of the register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | MSG_AW | Doorbell address of the message |
| msg_dev | output | 12 | Device ID payload |
| msg_evt | output | 10 | Event ID payload |

## Verification
On every cycle, the assertions check the following:
- The message payload and valid stay steady while the message is stalled.
- Valid drops after each accepted handshake.
- A message is raised only when some pin is owed one.
- A write of 1 to the clear bank clears the pending bit.
- Reads of unmapped offsets return zero.

Other properties only the bench scenarios can show. These are the mapping from each pin's register slots to its payload, the difference between edge and level triggering, the silence of a pending pin, the level refire after a clear, and the round-robin order. The bench shows them by sweeping all pins of a 64-pin configuration against identifiers it computes arithmetically.

// File: rtl/w2m_pkg.sv
package w2m_pkg;
  localparam int DEV_W = 12;
  localparam int EVT_W = 10;
  localparam int VEC_W = DEV_W + EVT_W;

  localparam logic [31:0] TYPE_BASE = 32'h0000_0000;
  localparam logic [31:0] VEC_BASE  = 32'h0000_0200;
  localparam logic [31:0] CLR_BASE  = 32'h0000_A000;

  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_TYPE = 2'd1,
    BANK_VEC  = 2'd2,
    BANK_CLR  = 2'd3
  } bank_e;
endpackage

// File: rtl/w2m_sync.sv
module w2m_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/w2m_regfile.sv
module w2m_regfile
  import w2m_pkg::*;
#(
  parameter int NUM_PINS = 128,
  parameter int AW       = 16,
  localparam int WORDS   = NUM_PINS / 32,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int WSEL_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr_en,
  input  logic                cfg_rd_en,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [NUM_PINS-1:0] status,
  output logic [NUM_PINS-1:0] trig_level,
  output logic [NUM_PINS-1:0] clr_mask,
  input  logic                vec_rd_en,
  input  logic [IDX_W-1:0]    vec_rd_idx,
  output logic [VEC_W-1:0]    vec_rd_q
);
  logic [31:0]         a32;
  bank_e               bank;
  logic [IDX_W-1:0]    pin_idx;
  logic [WSEL_W-1:0]   w_idx;

  logic [NUM_PINS-1:0] type_q;
  logic [VEC_W-1:0]    vec_mem [NUM_PINS];
  logic [NUM_PINS-1:0] vec_vld;
  logic [VEC_W-1:0]    vec_raw_q;
  logic                vec_raw_vld_q;

  assign a32 = 32'(cfg_addr);

  // address decode: one bank per range, everything else unmapped
  always_comb begin
    bank    = BANK_NONE;
    pin_idx = '0;
    w_idx   = '0;
    if (a32 >= VEC_BASE && a32 < VEC_BASE + 32'(NUM_PINS * 4)) begin
      bank    = BANK_VEC;
      pin_idx = IDX_W'((a32 - VEC_BASE) >> 2);
    end else if (a32 < TYPE_BASE + 32'(WORDS * 4)) begin
      bank  = BANK_TYPE;
      w_idx = WSEL_W'((a32 - TYPE_BASE) >> 2);
    end else if (a32 >= CLR_BASE && a32 < CLR_BASE + 32'(WORDS * 4)) begin
      bank  = BANK_CLR;
      w_idx = WSEL_W'((a32 - CLR_BASE) >> 2);
    end
  end

  // trigger-mode bank
  always_ff @(posedge clk) begin
    if (rst) begin
      type_q <= '0;
    end else if (cfg_wr_en && bank == BANK_TYPE) begin
      type_q[32*w_idx +: 32] <= cfg_wdata;
    end
  end
  assign trig_level = type_q;

  // vector storage: plain memory plus a reset-cleared valid bit per entry
  always_ff @(posedge clk) begin
    if (cfg_wr_en && bank == BANK_VEC) begin
      vec_mem[pin_idx] <= cfg_wdata[VEC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_vld <= '0;
    end else if (cfg_wr_en && bank == BANK_VEC) begin
      vec_vld[pin_idx] <= 1'b1;
    end
  end

  // message-side read port
  always_ff @(posedge clk) begin
    if (vec_rd_en) begin
      vec_raw_q <= vec_mem[vec_rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_raw_vld_q <= 1'b0;
    end else if (vec_rd_en) begin
      vec_raw_vld_q <= vec_vld[vec_rd_idx];
    end
  end

  assign vec_rd_q = vec_raw_vld_q ? vec_raw_q : '0;

  // write-1-to-clear pulse towards the pending logic
  always_comb begin
    clr_mask = '0;
    if (cfg_wr_en && bank == BANK_CLR) begin
      clr_mask[32*w_idx +: 32] = cfg_wdata;
    end
  end

  // registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd_en) begin
      unique case (bank)
        BANK_TYPE: cfg_rdata <= type_q[32*w_idx +: 32];
        BANK_VEC:  cfg_rdata <= vec_vld[pin_idx] ? 32'(vec_mem[pin_idx]) : 32'd0;
        BANK_CLR:  cfg_rdata <= status[32*w_idx +: 32];
        default:   cfg_rdata <= 32'd0;
      endcase
    end
  end
endmodule

// File: rtl/w2m_pend.sv
module w2m_pend #(
  parameter int NUM_PINS = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_s,
  input  logic [NUM_PINS-1:0] trig_level,
  input  logic [NUM_PINS-1:0] clr_mask,
  input  logic [NUM_PINS-1:0] take,
  output logic [NUM_PINS-1:0] status,
  output logic [NUM_PINS-1:0] owed
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] status_q;
  logic [NUM_PINS-1:0] owed_q;
  logic [NUM_PINS-1:0] fire;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    // level pins fire while high; edge pins only on a fresh 0->1 step
    assign fire[g] = pin_s[g] && !status_q[g] && (trig_level[g] || !prev_q[g]);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[g]   <= 1'b0;
        status_q[g] <= 1'b0;
        owed_q[g]   <= 1'b0;
      end else begin
        prev_q[g]   <= pin_s[g];
        status_q[g] <= (status_q[g] && !clr_mask[g]) || fire[g];
        owed_q[g]   <= (owed_q[g] && !take[g]) || fire[g];
      end
    end
  end

  assign status = status_q;
  assign owed   = owed_q;
endmodule

// File: rtl/w2m_rr_arb.sv
module w2m_rr_arb #(
  parameter int N      = 128,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  input  logic             adv,
  output logic             gnt_vld,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] last_q;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last_q) + k) % N;
      if (!gnt_vld && req[j]) begin
        gnt_vld = 1'b1;
        gnt_idx = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= IDX_W'(N - 1);
    end else if (adv && gnt_vld) begin
      last_q <= gnt_idx;
    end
  end
endmodule

// File: rtl/wire2msg_bridge.sv
module wire2msg_bridge
  import w2m_pkg::*;
#(
  parameter int              NUM_PINS = 128,
  parameter int              MSG_AW   = 32,
  parameter logic [MSG_AW-1:0] DOORBELL = MSG_AW'(32'hFEE0_1040),
  localparam int             IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                cfg_wr_en,
  input  logic                cfg_rd_en,
  input  logic [15:0]         cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [MSG_AW-1:0]   msg_addr,
  output logic [DEV_W-1:0]    msg_dev,
  output logic [EVT_W-1:0]    msg_evt
);
  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] trig_level;
  logic [NUM_PINS-1:0] clr_mask;
  logic [NUM_PINS-1:0] take;
  logic [NUM_PINS-1:0] status_w;
  logic [NUM_PINS-1:0] owed_w;
  logic                gnt_vld;
  logic [IDX_W-1:0]    gnt_idx;
  logic                launch;
  logic                valid_q;
  logic [VEC_W-1:0]    vec_q;

  w2m_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .d_async(irq_in), .d_sync(pin_s)
  );

  w2m_regfile #(.NUM_PINS(NUM_PINS), .AW(16)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .status(status_w), .trig_level(trig_level), .clr_mask(clr_mask),
    .vec_rd_en(launch), .vec_rd_idx(gnt_idx), .vec_rd_q(vec_q)
  );

  w2m_pend #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk(clk), .rst(rst), .pin_s(pin_s), .trig_level(trig_level),
    .clr_mask(clr_mask), .take(take), .status(status_w), .owed(owed_w)
  );

  w2m_rr_arb #(.N(NUM_PINS)) u_arb (
    .clk(clk), .rst(rst), .req(owed_w), .adv(launch),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  // a new message is loaded only into an empty output slot
  assign launch = !valid_q && gnt_vld;

  always_comb begin
    take = '0;
    if (launch) take[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (launch) begin
      valid_q <= 1'b1;
    end else if (valid_q && msg_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign msg_valid = valid_q;
  assign msg_addr  = DOORBELL;
  assign msg_dev   = vec_q[DEV_W-1:0];
  assign msg_evt   = vec_q[VEC_W-1:DEV_W];
endmodule

module w2m_checker #(
  parameter int NUM_PINS = 128
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_wr_en,
  input logic                cfg_rd_en,
  input logic [15:0]         cfg_addr,
  input logic                cfg_wdata0,
  input logic [31:0]         cfg_rdata,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [11:0]         msg_dev,
  input logic [9:0]          msg_evt,
  input logic                status0,
  input logic [NUM_PINS-1:0] owed
);
  logic unmapped;
  assign unmapped = (32'(cfg_addr) >= 32'h200 + 32'(NUM_PINS * 4)) &&
                    (32'(cfg_addr) < 32'hA000);

  p_stable_payload_r8: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_dev) && $stable(msg_evt));

  p_drop_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready |=> !msg_valid);

  p_launch_needs_owed_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(|owed));

  p_unmapped_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_en && unmapped |=> cfg_rdata == 32'd0);

  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_en && cfg_addr == 16'hA000 && cfg_wdata0 |=> !status0);
endmodule

bind wire2msg_bridge w2m_checker #(.NUM_PINS(NUM_PINS)) u_w2m_chk (
  .clk(clk), .rst(rst),
  .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
  .cfg_wdata0(cfg_wdata[0]), .cfg_rdata(cfg_rdata),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_dev(msg_dev), .msg_evt(msg_evt),
  .status0(status_w[0]), .owed(owed_w)
);

// File: tb/wire2msg_bridge_bench.sv
module wire2msg_bridge_bench;
  localparam int NP = 64;
  localparam logic [31:0] DB = 32'hFEE0_1040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NP-1:0] irq_in = '0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_rd_en = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [31:0] msg_addr;
  logic [11:0] msg_dev;
  logic [9:0]  msg_evt;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int last_pin = NP - 1;
  logic [9:0] evt_m [NP];

  always #2 clk = ~clk;

  wire2msg_bridge #(.NUM_PINS(NP), .MSG_AW(32), .DOORBELL(DB)) u_wire2msg_bridge (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_dev(msg_dev), .msg_evt(msg_evt)
  );

  function automatic logic [11:0] dev_of(int p);
    return 12'(p * 41 + 7);
  endfunction
  function automatic bit is_level(int p);
    return (p % 4) == 3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    cfg_addr = a; cfg_rd_en = 1'b1;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    d = cfg_rdata;
  endtask

  // waits for a message, optionally stalls it, then accepts it
  task automatic get_msg(input int hold, output bit got, output int pin, output logic [9:0] e);
    logic [11:0] d;
    got = 0; pin = -1; e = '0; msg_ready = 1'b0;
    for (int t = 0; t < 40 && !got; t++) begin
      @(negedge clk);
      if (msg_valid) got = 1;
    end
    if (got) begin
      d = msg_dev; e = msg_evt;
      pin = (int'(d) - 7) / 41;
      chk(msg_addr == DB, "R5 doorbell", msg_addr, DB);
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(msg_valid && msg_dev == d && msg_evt == e, "R8 stall hold",
            {msg_valid, 9'd0, msg_evt, msg_dev}, {1'b1, 9'd0, e, d});
      end
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
      chk(!msg_valid, "R7 valid drops after accept", 32'(msg_valid), 0);
      last_pin = pin;
    end
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 0;
    msg_ready = 1'b0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
    chk(!seen, req, 32'(seen), 0);
  endtask

  task automatic pulse(input logic [NP-1:0] m);
    irq_in = irq_in | m;
    repeat (3) @(negedge clk);
    irq_in = irq_in & ~m;
  endtask

  function automatic int rr_next(logic [NP-1:0] pend, int last);
    for (int k = 1; k <= NP; k++) begin
      int j = (last + k) % NP;
      if (pend[j]) return j;
    end
    return -1;
  endfunction

  task automatic rr_round(input logic [NP-1:0] set);
    logic [NP-1:0] pend;
    bit got; int pin; logic [9:0] e;
    int exp_pin;
    logic [31:0] d;
    pend = set;
    pulse(set);
    for (int n = 0; n < $countones(set); n++) begin
      exp_pin = rr_next(pend, last_pin);
      get_msg(0, got, pin, e);
      chk(got && pin == exp_pin, "R9 round-robin order", 32'(pin), 32'(exp_pin));
      pend[exp_pin] = 1'b0;
    end
    wr(16'hA000, 32'hFFFF_FFFF);
    wr(16'hA004, 32'hFFFF_FFFF);
    rd(16'hA000, d);
    chk(d == 0, "R4 clear all", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit got; int pin; logic [9:0] e;
    logic [31:0] vexp;

    repeat (5) @(negedge clk);
    chk(!msg_valid, "R1 valid in reset", 32'(msg_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset contents
    for (int w = 0; w < 2; w++) begin
      rd(16'(4 * w), d);          chk(d == 0, "R1 type reset", d, 0);
      rd(16'(16'hA000 + 4 * w), d); chk(d == 0, "R1 pending reset", d, 0);
    end
    rd(16'h0200, d); chk(d == 0, "R1 vector reset", d, 0);
    rd(16'h02FC, d); chk(d == 0, "R1 vector reset", d, 0);
    chk(!msg_valid, "R1 valid after reset", 32'(msg_valid), 0);

    // configure every pin; upper bits written as ones must read back 0
    for (int p = 0; p < NP; p++) begin
      evt_m[p] = 10'(p * 13 + 3);
      wr(16'(16'h200 + 4 * p), 32'hFFC0_0000 | {10'd0, evt_m[p], dev_of(p)});
    end
    wr(16'h0000, 32'h8888_8888);
    wr(16'h0004, 32'h8888_8888);

    // R2 / R3 read back, R11 read timing
    for (int p = 0; p < NP; p++) begin
      rd(16'(16'h200 + 4 * p), d);
      vexp = {10'd0, evt_m[p], dev_of(p)};
      chk(d == vexp, "R2 vector readback", d, vexp);
    end
    rd(16'h0004, d); chk(d == 32'h8888_8888, "R3 type readback R11", d, 32'h8888_8888);

    // R2 read-modify-write of event only
    rd(16'h0214, d);
    d = (d & ~32'h003F_F000) | (32'h2A5 << 12);
    wr(16'h0214, d);
    evt_m[5] = 10'h2A5;
    rd(16'h0214, d);
    chk(d[11:0] == dev_of(5) && d[21:12] == 10'h2A5, "R2 rmw keeps device", d,
        {10'd0, 10'h2A5, dev_of(5)});

    // R10 unmapped offsets
    wr(16'h0100, 32'hFFFF_FFFF);
    wr(16'h0300, 32'hFFFF_FFFF);
    wr(16'hA008, 32'hFFFF_FFFF);
    rd(16'h0100, d); chk(d == 0, "R10 unmapped read", d, 0);
    rd(16'h0300, d); chk(d == 0, "R10 unmapped read", d, 0);
    rd(16'hA008, d); chk(d == 0, "R10 unmapped read", d, 0);
    rd(16'h0000, d); chk(d == 32'h8888_8888, "R10 type untouched", d, 32'h8888_8888);
    rd(16'h0200, d); chk(d == {10'd0, evt_m[0], dev_of(0)}, "R10 vector untouched", d,
                         {10'd0, evt_m[0], dev_of(0)});

    // sweep every pin
    for (int p = 0; p < NP; p++) begin
      logic [15:0] ca;
      logic [31:0] bit_p;
      ca = 16'(16'hA000 + 4 * (p / 32));
      bit_p = 32'd1 << (p % 32);
      if (is_level(p)) irq_in[p] = 1'b1;
      else pulse(NP'(1) << p);
      get_msg((p == 0) ? 4 : 0, got, pin, e);
      chk(got && pin == p, "R5 message pin", 32'(pin), 32'(p));
      chk(e == evt_m[p], "R5 event payload", 32'(e), 32'(evt_m[p]));
      rd(ca, d); chk(d == bit_p, "R4 pending set", d, bit_p);
      if (is_level(p)) begin
        quiet(10, "R6 level silent while pending");
        wr(ca, 32'd0);
        rd(ca, d); chk(d == bit_p, "R4 write zero no effect", d, bit_p);
        wr(ca, bit_p);
        get_msg(0, got, pin, e);
        chk(got && pin == p, "R6 level refire after clear", 32'(pin), 32'(p));
        irq_in[p] = 1'b0;
        repeat (5) @(negedge clk);
        wr(ca, bit_p);
        quiet(12, "R6 level low stays quiet");
      end else begin
        pulse(NP'(1) << p);
        quiet(12, "R6 edge silent while pending");
        wr(ca, 32'd0);
        rd(ca, d); chk(d == bit_p, "R4 write zero no effect", d, bit_p);
        wr(ca, bit_p);
        rd(ca, d); chk(d == 0, "R4 write one clears", d, 0);
        quiet(12, "R5 edge held low no fire");
      end
    end

    // R9 round robin with wrap
    rr_round((NP'(1) << 2) | (NP'(1) << 10) | (NP'(1) << 40) | (NP'(1) << 41));
    rr_round((NP'(1) << 1) | (NP'(1) << 40) | (NP'(1) << 50) | (NP'(1) << 62));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule